// File: doc/BRIEF.md
# Two-Phase Pipeline Overrun Test Sequencer

This block is a synchronous tester for a linear self-timed pipeline of `N_STAGES` stages that uses transition-signalled request/acknowledge handshakes. It drives the pipeline's input request and output acknowledge and watches the input acknowledge and output request. It looks for one kind of hold-time fault, control overrun, in which a stage lets a new request overwrite the one it holds. Each such fault loses two transitions, so the pipeline ends up holding fewer items than it should. The two handshake inputs come from the asynchronous side and pass through synchronisers before the sequencer uses them.

A test starts on a `start` pulse. The sequencer fills the pipeline with `N_STAGES` items while it holds the output acknowledge, so nothing leaves. It then offers one more item, which a healthy pipeline cannot accept. It removes exactly one item from the output end, which sends a bubble backward to the input. A healthy pipeline uses that bubble to accept the pending item and is then full again. A final probe item is offered for a bounded time. If the probe is acknowledged, the pipeline has lost items and the test fails. If it is not, the test passes. Every wait is bounded by a timeout. A timeout while the sequencer expects progress is reported as a stuck pipeline.

The result code is held until the next accepted start. `done` pulses for one cycle when the result is written.

Top module: `ovr_test_seq`

## Requirements
- R1: After reset, `in_req`, `out_ack` and `done` are 0 and `result` is 2'b00 (no result).
- R2: Every toggle of `in_req` or `out_ack` is one handshake event, and the two never toggle in the same cycle. An offer counts as acknowledged once `in_ack` has the same level as `in_req`.
- R3: The sequencer toggles `in_req` only after the previous offer has been acknowledged. During the fill it makes exactly `N_STAGES` acknowledged offers while `out_ack` stays unchanged.
- R4: After the fill, one extra item is offered and watched for `TIMEOUT` cycles. If it is acknowledged within that window, the result is 2'b10 (fail).
- R5: The sequencer toggles `out_ack` exactly once per test, and only while `out_req` differs from `out_ack`, that is, while an item is waiting at the output.
- R6: After the bubble, the sequencer waits for the extra item to be acknowledged and then offers a probe item. If the probe is acknowledged within `TIMEOUT` cycles, the result is 2'b10 (fail). Otherwise it is 2'b01 (pass).
- R7: If an expected acknowledge or output item does not arrive within `TIMEOUT` cycles, during the fill, while waiting for an output item, or after the bubble, the result is 2'b11 (stuck).
- R8: A test on a healthy pipeline applies `N_STAGES`+3 handshake events: `N_STAGES`+2 toggles of `in_req` and one toggle of `out_ack`.
- R9: `done` is high for exactly one cycle per test, in the cycle the result is written. `result` then stays unchanged until the next accepted `start`, which clears it to 2'b00.
- R10: A `start` pulse that arrives while a test is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a test when idle |
| in_req | output | 1 | Transition-signalled request to the pipeline input |
| in_ack | input | 1 | Transition-signalled acknowledge from the pipeline input (asynchronous) |
| out_req | input | 1 | Transition-signalled request from the pipeline output (asynchronous) |
| out_ack | output | 1 | Transition-signalled acknowledge to the pipeline output |
| done | output | 1 | One-cycle pulse when a result is written |
| result | output | 2 | 00 none, 01 pass, 10 fail, 11 stuck |

## Verification
The assertions check on every cycle the handshake rules that hold for any pipeline:
- a new offer only after the previous one is acknowledged;
- no simultaneous toggles of `in_req` and `out_ack`;
- an output acknowledge only while an item is waiting;
- `done` lasting one cycle;
- a result that stays put between tests.

The classification itself can only be shown by the bench scenarios, which drive a behavioural pipeline model:
- a healthy pipeline, to check the pass verdict and the event count;
- a pipeline that drops two items at the bubble, to check the fail verdict;
- a pipeline with one slot too many, to check the early fail at the extra offer;
- a dead input and a dead output, to check the stuck verdict.

// File: rtl/ovr_test_pkg.sv
// Shared types for the overrun test sequencer: result codes and FSM states.
// Assumes: result encoding is visible at the top-level port as 2 bits.
package ovr_test_pkg;

    typedef enum logic [1:0] {
        RES_NONE  = 2'b00,
        RES_PASS  = 2'b01,
        RES_FAIL  = 2'b10,
        RES_STUCK = 2'b11
    } res_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FILL_OFFER,
        S_FILL_WAIT,
        S_EXTRA_OFFER,
        S_EXTRA_WATCH,
        S_OUT_WAIT,
        S_BUBBLE_WAIT,
        S_PROBE_OFFER,
        S_PROBE_WATCH
    } state_e;

endpackage

// File: rtl/ovr_sync.sv
// Level synchroniser for one asynchronous handshake wire.
// Assumes: STAGES >= 1; the input is a level that changes rarely
// relative to the clock, as transition signalling guarantees.
module ovr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the input level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ovr_timer.sv
// Saturating wait timer: counts while run is high, restarts on clear,
// and flags expiry once LIMIT cycles have been counted.
// Assumes: LIMIT >= 1.
module ovr_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    // Count up to the limit, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (clear)             cnt <= '0;
        else if (run && cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);
endmodule

// File: rtl/ovr_test_seq.sv
// Control-overrun test sequencer for a linear two-phase pipeline.
// The sequence is: fill N_STAGES items, offer one extra item, release one
// bubble at the output, wait for the extra item to be taken, then probe
// once more. A probe that is acknowledged means lost transitions (fail).
// Assumes: the pipeline starts empty with all handshake levels at 0 after
// reset, and in_ack/out_req are asynchronous levels.
module ovr_test_seq
    import ovr_test_pkg::*;
#(
    parameter int N_STAGES    = 4,
    parameter int TIMEOUT     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       in_req,
    input  logic       in_ack,
    input  logic       out_req,
    output logic       out_ack,
    output logic       done,
    output logic [1:0] result
);
    localparam int CNT_W = $clog2(N_STAGES + 1);
    localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(N_STAGES - 1);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] fill_cnt;
    logic             in_req_q, out_ack_q, done_q;
    res_e             result_q, res_d;
    logic             flip_req, flip_ack, finish;
    logic             in_ack_s, out_req_s;
    logic             ack_ok, item_out, expired, busy;

    ovr_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .d(in_ack), .q(in_ack_s)
    );
    ovr_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .d(out_req), .q(out_req_s)
    );

    ovr_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(state_d != state_q || state_q == S_IDLE),
        .run(busy),
        .expired(expired)
    );

    // Handshake status from the synchronised levels.
    always_comb begin
        ack_ok   = (in_ack_s == in_req_q);
        item_out = (out_req_s != out_ack_q);
        busy     = (state_q != S_IDLE);
    end

    // Next state, handshake toggles and verdict.
    always_comb begin
        state_d  = state_q;
        flip_req = 1'b0;
        flip_ack = 1'b0;
        finish   = 1'b0;
        res_d    = RES_NONE;
        case (state_q)
            S_IDLE: begin
                if (start) state_d = S_FILL_OFFER;
            end
            S_FILL_OFFER: begin
                flip_req = 1'b1;
                state_d  = S_FILL_WAIT;
            end
            S_FILL_WAIT: begin
                if (ack_ok) begin
                    state_d = (fill_cnt == LAST_FILL) ? S_EXTRA_OFFER : S_FILL_OFFER;
                end else if (expired) begin
                    finish  = 1'b1;
                    res_d   = RES_STUCK;
                    state_d = S_IDLE;
                end
            end
            S_EXTRA_OFFER: begin
                flip_req = 1'b1;
                state_d  = S_EXTRA_WATCH;
            end
            S_EXTRA_WATCH: begin
                if (ack_ok) begin
                    finish  = 1'b1;
                    res_d   = RES_FAIL;
                    state_d = S_IDLE;
                end else if (expired) begin
                    state_d = S_OUT_WAIT;
                end
            end
            S_OUT_WAIT: begin
                if (item_out) begin
                    flip_ack = 1'b1;
                    state_d  = S_BUBBLE_WAIT;
                end else if (expired) begin
                    finish  = 1'b1;
                    res_d   = RES_STUCK;
                    state_d = S_IDLE;
                end
            end
            S_BUBBLE_WAIT: begin
                if (ack_ok) begin
                    state_d = S_PROBE_OFFER;
                end else if (expired) begin
                    finish  = 1'b1;
                    res_d   = RES_STUCK;
                    state_d = S_IDLE;
                end
            end
            S_PROBE_OFFER: begin
                flip_req = 1'b1;
                state_d  = S_PROBE_WATCH;
            end
            S_PROBE_WATCH: begin
                if (ack_ok) begin
                    finish  = 1'b1;
                    res_d   = RES_FAIL;
                    state_d = S_IDLE;
                end else if (expired) begin
                    finish  = 1'b1;
                    res_d   = RES_PASS;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State, handshake levels, fill count and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            fill_cnt  <= '0;
            in_req_q  <= 1'b0;
            out_ack_q <= 1'b0;
            done_q    <= 1'b0;
            result_q  <= RES_NONE;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (flip_req) in_req_q  <= ~in_req_q;
            if (flip_ack) out_ack_q <= ~out_ack_q;
            if (state_q == S_IDLE)
                fill_cnt <= '0;
            else if (state_q == S_FILL_WAIT && ack_ok)
                fill_cnt <= fill_cnt + 1'b1;
            if (finish)
                result_q <= res_d;
            else if (state_q == S_IDLE && start)
                result_q <= RES_NONE;
        end
    end

    assign in_req  = in_req_q;
    assign out_ack = out_ack_q;
    assign done    = done_q;
    assign result  = result_q;
endmodule

// Property checker for the sequencer's handshake and result rules.
// Assumes: bound to ovr_test_seq; sees its ports and the busy signal.
module ovr_test_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       in_req,
    input logic       in_ack,
    input logic       out_req,
    input logic       out_ack,
    input logic       done,
    input logic [1:0] result,
    input logic       busy
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!done && result == 2'b00));

    assert_no_dual_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !((in_req != $past(in_req)) && (out_ack != $past(out_ack))));

    assert_offer_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req != $past(in_req)) |-> $past(in_ack == in_req));

    assert_bubble_needs_item_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ack != $past(out_ack)) |-> $past(out_req != out_ack));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && !busy) |=> ($stable(result) || done));
endmodule

bind ovr_test_seq ovr_test_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .in_req(in_req), .in_ack(in_ack),
    .out_req(out_req), .out_ack(out_ack), .done(done), .result(result), .busy(busy)
);

// File: tb/ovr_test_seq_tb.sv
// Bench: a behavioural two-phase pipeline model (healthy or faulty) answers
// the sequencer; a per-clock monitor checks handshake rules against the model.
module ovr_test_seq_tb;
    localparam int N  = 4;
    localparam int TO = 32;
    localparam int M_HEALTHY = 0, M_LOSSY = 1, M_DEAD = 2, M_BIG = 3, M_NOOUT = 4;

    logic clk = 0, rst_n = 0, start = 0;
    logic in_req, out_ack, done;
    logic in_ack = 0, out_req = 0;
    logic [1:0] result;

    int checks = 0, fails = 0;
    int mode = M_HEALTHY;
    int occ = 0;
    bit presented = 0, seen_ack = 0;
    bit prev_req = 0, prev_ack = 0;
    int req_toggles = 0, ack_toggles = 0, done_pulses = 0, viol = 0;

    always #10 clk = ~clk;

    ovr_test_seq #(.N_STAGES(N), .TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_req(in_req), .in_ack(in_ack),
        .out_req(out_req), .out_ack(out_ack), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor, then pipeline model, every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_req != prev_req) begin
                req_toggles++;
                if (in_ack != prev_req) viol++;          // R3: previous offer unacked
            end
            if (out_ack != prev_ack) begin
                ack_toggles++;
                if (!presented) viol++;                  // R5: no item waiting
            end
            if (in_req != prev_req && out_ack != prev_ack) viol++; // R2
            if (done) done_pulses++;
            prev_req = in_req;
            prev_ack = out_ack;
            if (in_req != in_ack && mode != M_DEAD &&
                occ < ((mode == M_BIG) ? N + 1 : N)) begin
                in_ack = ~in_ack;
                occ++;
            end
            if (out_ack != seen_ack) begin
                seen_ack  = out_ack;
                presented = 0;
                occ--;
                if (mode == M_LOSSY) occ = (occ > 2) ? occ - 2 : 0;
            end
            if (occ > 0 && !presented && mode != M_NOOUT) begin
                out_req   = ~out_req;
                presented = 1;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; start = 0;
        in_ack = 0; out_req = 0; occ = 0; presented = 0; seen_ack = 0;
        prev_req = 0; prev_ack = 0;
        req_toggles = 0; ack_toggles = 0; done_pulses = 0; viol = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic run(input int m, input int exp_res, input int exp_req,
                       input int exp_ack, input bit mid_start, input string tag);
        int waited;
        logic [1:0] held;
        mode = m;
        do_reset();
        start = 1; @(negedge clk); start = 0;
        if (mid_start) begin
            repeat (5) @(negedge clk);
            start = 1; @(negedge clk); start = 0;
        end
        waited = 0;
        while (!done && waited < 3000) begin @(negedge clk); waited++; end
        check(waited < 3000, {tag, " watchdog"}, waited, 0);
        check(result == 2'(exp_res), {tag, " result"}, result, exp_res);
        held = result;
        repeat (20) @(negedge clk);
        check(result == held && done_pulses == 1, {tag, " R9 one done, result held"},
              done_pulses, 1);
        check(req_toggles == exp_req, {tag, " in_req events"}, req_toggles, exp_req);
        check(ack_toggles == exp_ack, {tag, " R5 out_ack events"}, ack_toggles, exp_ack);
        check(viol == 0, {tag, " R2 R3 R5 per-cycle handshake rules"}, viol, 0);
    endtask

    initial begin
        do_reset();
        check(in_req == 0 && out_ack == 0 && done == 0 && result == 2'b00,
              "R1 reset state", {in_req, out_ack, done, result}, 0);
        // R6 R8: healthy pipeline passes with N+3 events
        run(M_HEALTHY, 1, N + 2, 1, 0, "R6 R8 healthy");
        // R6: two items lost at the bubble, probe accepted -> fail
        run(M_LOSSY, 2, N + 2, 1, 0, "R6 lossy");
        // R4: one slot too many, extra item accepted early -> fail
        run(M_BIG, 2, N + 1, 0, 0, "R4 oversized");
        // R7: no acknowledge at all during fill -> stuck
        run(M_DEAD, 3, 1, 0, 0, "R7 dead input");
        // R7: output never presents an item -> stuck
        run(M_NOOUT, 3, N + 1, 0, 0, "R7 dead output");
        // R10: start during a test is ignored, outcome unchanged
        run(M_HEALTHY, 1, N + 2, 1, 1, "R10 mid start");
        // R9: a new start clears the held result
        start = 1; @(negedge clk); start = 0;
        check(result == 2'b00, "R9 result cleared on start", result, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule